// File: doc/BRIEF.md
# Registered Five-Function Logic Selector

The block holds a four-bit operand word and a three-bit function code in an input register that is reloaded on every rising clock edge. Five fixed Boolean functions of the registered operand bits are evaluated side by side. A multiplexer then passes the result of the function named by the registered code to a single output bit. An upstream source can therefore offer a fresh operand and code every cycle, and the selected answer is ready one cycle later.

The operand bits are called A, B, C and D, with A in bit 3 and D in bit 0. A parameter decides whether the functions are built from their literal multi-level expressions or from minimised two-level sum-of-products forms; the two must be indistinguishable at the ports. A second parameter adds an output register, which costs one more cycle of latency and shortens the path to the output pin.

Top module: `lfsel_top`

## Requirements
- R1: On each rising edge the block captures `data_i` (A = bit 3, B = bit 2, C = bit 1, D = bit 0) and `sel_i`; with `OUT_REG` = 0, `bit_o` shows the selected function of those operands from that edge until the next one.
- R2: Code 3'b000 selects F = ABC + A(CD + B') + CD'(A + B)', whose true rows as a 16-bit truth mask indexed by {A,B,C,D} are 16'hCF04.
- R3: Code 3'b001 selects G = A'B + CB'(A + D) + CB(AD' + CD), truth mask 16'hCCF8.
- R4: Code 3'b010 selects H = A'B'CD + A'B'(C' + D') + (ABC)', truth mask 16'h3FFF, which is 0 only when A, B and C are all 1.
- R5: Code 3'b011 selects I = D'(A + B') + CD(A' + B)', truth mask 16'h5D05.
- R6: Code 3'b100 selects J = A'(B + D') + A'B'C'D + AB(C' + D)', truth mask 16'h40F7.
- R7: Codes 3'b101, 3'b110 and 3'b111 drive `bit_o` to 0 for every operand value.
- R8: A synchronous active-high `rst_i` clears every register to zero, whatever `data_i` and `sel_i` hold; after a reset edge `bit_o` is 0, which is F of all-zero operands.
- R9: `SOP_FORM` = 1 gives the same output as `SOP_FORM` = 0 for all 16 operand values under all 8 codes.
- R10: `OUT_REG` = 1 delays `bit_o` by exactly one further cycle relative to `OUT_REG` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | 4 | Operand word {A,B,C,D}, A in the top bit |
| sel_i | input | 3 | Function code, 0 to 4 valid |
| bit_o | output | 1 | Selected function result |

## Verification
On every cycle, the in-line checks confirm that H falls only when A, B and C are all set, that F and G are both true whenever A and C are, that a code above 4 never produces a 1, and that the first cycle after reset shows 0. The exact truth table of each function and the equality of the literal and minimised builds can only be shown by the bench, which sweeps all 128 operand and code pairs. The same holds for the added output latency and for a reset that overrides a live input which would otherwise give 1.

// File: rtl/lfsel_pkg.sv
package lfsel_pkg;
    localparam int DATA_W   = 4;
    localparam int NUM_FUNC = 5;
    localparam int SEL_W    = $clog2(NUM_FUNC);

    typedef enum logic [SEL_W-1:0] {
        SEL_F = 3'd0,
        SEL_G = 3'd1,
        SEL_H = 3'd2,
        SEL_I = 3'd3,
        SEL_J = 3'd4
    } func_sel_e;

    typedef logic [NUM_FUNC-1:0] func_vec_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [SEL_W-1:0]  sel;
    } operand_t;

    typedef struct packed {
        operand_t ops;
        logic     out;
    } state_t;
endpackage

// File: rtl/lfsel_eval.sv
module lfsel_eval
    import lfsel_pkg::*;
#(
    parameter bit SOP_FORM = 1'b0
) (
    input  logic [DATA_W-1:0] data_i,
    output func_vec_t         res_o
);
    logic a, b, c, d;
    assign a = data_i[3];
    assign b = data_i[2];
    assign c = data_i[1];
    assign d = data_i[0];

    generate
        if (SOP_FORM) begin : g_sop
            always_comb begin
                res_o[SEL_F] = (a & ~b) | (a & c) | (~b & c & ~d);
                res_o[SEL_G] = (~a & b) | (a & c) | (~a & c & d);
                res_o[SEL_H] = ~a | ~b | ~c;
                res_o[SEL_I] = (a & ~d) | (~b & ~d) | (a & ~b & c);
                res_o[SEL_J] = (~a & b) | (~a & ~c) | (~a & ~d) | (b & c & ~d);
            end
        end else begin : g_literal
            always_comb begin
                res_o[SEL_F] = (a & b & c) | (a & ((c & d) | ~b)) | (c & ~d & ~(a | b));
                res_o[SEL_G] = (~a & b) | (c & ~b & (a | d))
                             | (c & b & ((a & ~d) | (c & d)));
                res_o[SEL_H] = (~a & ~b & c & d) | (~a & ~b & (~c | ~d)) | ~(a & b & c);
                res_o[SEL_I] = (~d & (a | ~b)) | (c & d & ~(~a | b));
                res_o[SEL_J] = (~a & (b | ~d)) | (~a & ~b & ~c & d) | (a & b & ~(~c | d));
            end
        end
    endgenerate

    always_comb begin
        assert_h_low_only_abc_R4: assert ((res_o[SEL_H] == 1'b0) == (data_i[3:1] == 3'b111))
            else $error("H low does not match A&B&C");
        assert_f_g_when_ac_R2: assert (!(data_i[3] && data_i[1]) || (res_o[SEL_F] && res_o[SEL_G]))
            else $error("F or G low while A and C set");
    end
endmodule

// File: rtl/lfsel_mux.sv
module lfsel_mux
    import lfsel_pkg::*;
(
    input  func_vec_t        res_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < NUM_FUNC; i++) begin
            if (sel_i == SEL_W'(i)) bit_o = res_i[i];
        end
    end

    always_comb begin
        assert_unused_code_low_R7: assert (!(sel_i >= SEL_W'(NUM_FUNC)) || !bit_o)
            else $error("unused code produced a one");
    end
endmodule

// File: rtl/lfsel_top.sv
module lfsel_top
    import lfsel_pkg::*;
#(
    parameter bit SOP_FORM = 1'b0,
    parameter bit OUT_REG  = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              bit_o
);
    state_t    state_d, state_q;
    func_vec_t func_res;
    logic      mux_bit;

    lfsel_eval #(.SOP_FORM(SOP_FORM)) u_eval (
        .data_i (state_q.ops.data),
        .res_o  (func_res)
    );

    lfsel_mux u_mux (
        .res_i  (func_res),
        .sel_i  (state_q.ops.sel),
        .bit_o  (mux_bit)
    );

    always_comb begin
        state_d = state_q;
        if (rst_i) begin
            state_d = '0;
        end else begin
            state_d.ops.data = data_i;
            state_d.ops.sel  = sel_i;
            state_d.out      = mux_bit;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign bit_o = (OUT_REG != 1'b0) ? state_q.out : mux_bit;

    assert_low_after_reset_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !bit_o)
        else $error("output not low after reset");
endmodule

// File: tb/lfsel_top_test.sv
module lfsel_top_test;
    localparam int LIMIT = 20000;
    localparam logic [15:0] MASKS [5] = '{16'hCF04, 16'hCCF8, 16'h3FFF, 16'h5D05, 16'h40F7};
    // {code[2:0], data[3:0], expected}
    localparam logic [7:0] VEC [12] = '{
        {3'd0, 4'd2,  1'b1}, {3'd0, 4'd4,  1'b0},
        {3'd1, 4'd3,  1'b1}, {3'd1, 4'd8,  1'b0},
        {3'd2, 4'd14, 1'b0}, {3'd2, 4'd13, 1'b1},
        {3'd3, 4'd11, 1'b1}, {3'd3, 4'd9,  1'b0},
        {3'd4, 4'd3,  1'b0}, {3'd4, 4'd14, 1'b1},
        {3'd5, 4'd15, 1'b0}, {3'd7, 4'd0,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] data = 4'd0;
    logic [2:0] sel = 3'd0;
    logic       out_lit, out_sop;
    int         checks = 0, errors = 0, cyc = 0;
    logic       prev_exp = 1'b0, prev_lit = 1'b0;

    always #4 clk = ~clk;

    lfsel_top #(.SOP_FORM(1'b0), .OUT_REG(1'b0)) uut (
        .clk_i(clk), .rst_i(rst), .data_i(data), .sel_i(sel), .bit_o(out_lit));

    lfsel_top #(.SOP_FORM(1'b1), .OUT_REG(1'b1)) uut_sop (
        .clk_i(clk), .rst_i(rst), .data_i(data), .sel_i(sel), .bit_o(out_sop));

    function automatic logic ref_bit(input logic [2:0] s, input logic [3:0] d);
        if (s < 3'd5) return MASKS[s][d];
        return 1'b0;
    endfunction

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [2:0] s, input logic [3:0] d,
                        input logic e, input string tag);
        rst = r; sel = s; data = d;
        @(posedge clk);
        @(negedge clk);
        check(out_lit, e, tag);
        if (r) begin
            check(out_sop, 1'b0, "R8");
        end else begin
            check(out_sop, prev_exp, "R10");
            check(out_sop, prev_lit, "R9");
        end
        prev_exp = e;
        prev_lit = out_lit;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R8: reset overrides H of zero operands, which would be 1
        step(1'b1, 3'd2, 4'd0, 1'b0, "R8");
        step(1'b1, 3'd2, 4'd0, 1'b0, "R8");
        // R1: directed vectors, one-cycle capture to output
        for (int k = 0; k < 12; k++) begin
            step(1'b0, VEC[k][7:5], VEC[k][4:1], VEC[k][0], "R1");
        end
        // R2..R7, R9, R10: every code with every operand value
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 16; d++) begin
                step(1'b0, 3'(s), 4'(d), ref_bit(3'(s), 4'(d)), req_of(3'(s)));
            end
        end
        // R8: reset in mid-stream while input would give 1
        step(1'b0, 3'd4, 4'd0, 1'b1, "R6");
        step(1'b1, 3'd4, 4'd0, 1'b0, "R8");
        step(1'b0, 3'd3, 4'd0, 1'b1, "R5");
        // R7: unused code after a one
        step(1'b0, 3'd6, 4'd0, 1'b0, "R7");
        step(1'b0, 3'd2, 4'd15, 1'b0, "R4");
        step(1'b0, 3'd0, 4'd0, 1'b0, "R2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule